// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits between a requester and a low-level AUX transceiver port. It takes one request at a time through a ready/valid handshake: a 4-bit command, an address, a byte count of 1 to 16 and up to 16 bytes of write data. It holds the request in registers and presents it to the transceiver. It then classifies the response and either issues the same request again or finishes with a single result code.

The transceiver is modelled as a simple handshake. The controller raises `xcv_valid` until `xcv_ready` accepts the request. Later the transceiver returns one `rsp_valid` beat. That beat is a timeout, a hard failure, or a reply header byte with a returned data count. Sink deferrals and transport timeouts are retried under two separate budgets. Both budgets are cleared when a request is accepted. A non-zero padding nibble in a reply header never changes the outcome; it only sets a sticky warning output.

Top module: `aux_retry_ctrl`

## Requirements
- R1: `req_ready` is high only when no transaction is in flight. A request is taken on a cycle with `req_valid` and `req_ready` both high. From then until the `done` pulse, `req_ready` is low, and `req_valid` beats have no effect.
- R2: Every issue drives the accepted command, address, length and data on the `xcv_*` outputs. These stay stable while `xcv_valid` is high and `xcv_ready` is low. A retry drives the same values again.
- R3: The reply status is header bits [7:4]. Status 0 finishes with result 0 (success), and `reply_len` equals the `rsp_count` of that reply.
- R4: Status 1 and status 4 finish with result 1 (refused) after a single issue.
- R5: Status 2 triggers a new issue. The MAX_DEFERS-th status-2 reply of one request finishes with result 2 (deadline missed).
- R6: A response of kind 1 (timeout) triggers a new issue. The MAX_TIMEOUTS-th timeout of one request finishes with result 3 (timeout).
- R7: Status 8 finishes with result 4 (unsupported) after a single issue.
- R8: Any other status finishes with result 5 (integrity). A response of kind 2 (hard failure) finishes at once with result 6 (failure). Response kind 0 is a reply.
- R9: A reply whose header bits [3:0] are non-zero still gets the result its status selects. It also sets `pad_warn`, which stays high until reset.
- R10: The two budgets count independently and restart from zero on every accepted request. Up to MAX_DEFERS-1 defers and MAX_TIMEOUTS-1 timeouts may be mixed in one request, and a final ACK still succeeds.
- R11: `done` is high for exactly one cycle, the cycle after the deciding response beat. `reply_len` is 0 for any result other than success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_cmd | input | 4 | Request command |
| req_addr | input | ADDR_W | Request address |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write data, byte 0 in the low bits |
| xcv_valid | output | 1 | Request presented to the transceiver |
| xcv_ready | input | 1 | Transceiver accepts the request |
| xcv_cmd | output | 4 | Issued command |
| xcv_addr | output | ADDR_W | Issued address |
| xcv_len | output | 5 | Issued byte count |
| xcv_wdata | output | 128 | Issued write data |
| rsp_valid | input | 1 | Response beat from the transceiver |
| rsp_kind | input | 2 | 0 reply, 1 timeout, 2 hard failure |
| rsp_header | input | 8 | Reply header byte |
| rsp_count | input | 5 | Reply data count |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Completion code |
| reply_len | output | 5 | Reply data length on success |
| pad_warn | output | 1 | Sticky non-zero padding warning |

## Verification
The bench builds the controller with its default budgets of 16 defers and 5 timeouts, and a 20-bit address. These are the limits a real link runs with. With these values the bench can hit exhaustion exactly at the 16th defer and the 5th timeout. It can also hit the one-short cases that still succeed, and a mixed run of 15 defers plus 4 timeouts in one request. The short 5-bit length field also lets the bench check that a 16-byte count passes through unchanged.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_REFUSED   = 3'd1,
    RES_DEADLINE  = 3'd2,
    RES_TIMEOUT   = 3'd3,
    RES_UNSUP     = 3'd4,
    RES_INTEGRITY = 3'd5,
    RES_FAIL      = 3'd6
  } res_e;

  typedef enum logic [1:0] {
    XK_REPLY   = 2'd0,
    XK_TIMEOUT = 2'd1,
    XK_FAIL    = 2'd2
  } xk_e;

  localparam logic [3:0] ST_ACK       = 4'd0;
  localparam logic [3:0] ST_NACK      = 4'd1;
  localparam logic [3:0] ST_DEFER     = 4'd2;
  localparam logic [3:0] ST_I2C_NACK  = 4'd4;
  localparam logic [3:0] ST_I2C_DEFER = 4'd8;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } fsm_e;

endpackage

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_retry_pkg::*;
(
  input  logic [7:0] hdr,
  output logic       is_defer,
  output logic       pad_nz,
  output logic [2:0] code
);

  logic [3:0] status;

  assign status = hdr[7:4];
  assign pad_nz = |hdr[3:0];

  always_comb begin
    is_defer = 1'b0;
    code     = RES_INTEGRITY;
    case (status)
      ST_ACK:       code = RES_OK;
      ST_NACK:      code = RES_REFUSED;
      ST_I2C_NACK:  code = RES_REFUSED;
      ST_I2C_DEFER: code = RES_UNSUP;
      ST_DEFER: begin
        is_defer = 1'b1;
        code     = RES_DEADLINE;
      end
      default:      code = RES_INTEGRITY;
    endcase
  end

endmodule

// File: rtl/aux_retry_budget.sv
module aux_retry_budget #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_en = clr | bump;
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int MAX_BYTES    = 16,
  parameter int MAX_DEFERS   = 16,
  parameter int MAX_TIMEOUTS = 5,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1),
  localparam int DATA_W      = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              xcv_valid,
  input  logic              xcv_ready,
  output logic [3:0]        xcv_cmd,
  output logic [ADDR_W-1:0] xcv_addr,
  output logic [LEN_W-1:0]  xcv_len,
  output logic [DATA_W-1:0] xcv_wdata,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_kind,
  input  logic [7:0]        rsp_header,
  input  logic [LEN_W-1:0]  rsp_count,
  output logic              done,
  output logic [2:0]        result,
  output logic [LEN_W-1:0]  reply_len,
  output logic              pad_warn
);

  fsm_e              state_q, state_d;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d;
  logic [2:0]        res_q, res_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d;
  logic              pad_q, pad_d;
  logic              accept, in_wait;
  logic              bump_df, bump_to, df_last, to_last;
  logic              dec_defer, dec_pad;
  logic [2:0]        dec_code;

  aux_reply_decode u_dec (
    .hdr      (rsp_header),
    .is_defer (dec_defer),
    .pad_nz   (dec_pad),
    .code     (dec_code)
  );

  aux_retry_budget #(.LIMIT(MAX_DEFERS)) u_defer_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .bump  (bump_df),
    .last  (df_last)
  );

  aux_retry_budget #(.LIMIT(MAX_TIMEOUTS)) u_timeout_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .bump  (bump_to),
    .last  (to_last)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid & req_ready;
  assign in_wait   = (state_q == S_WAIT);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    res_d   = res_q;
    rlen_d  = rlen_q;
    pad_d   = pad_q;
    bump_df = 1'b0;
    bump_to = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) state_d = S_ISSUE;
      end
      S_ISSUE: begin
        if (xcv_ready) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (rsp_valid) begin
          case (rsp_kind)
            XK_TIMEOUT: begin
              bump_to = 1'b1;
              if (to_last) begin
                done_d = 1'b1;
                res_d  = RES_TIMEOUT;
                rlen_d = '0;
              end
            end
            XK_REPLY: begin
              if (dec_pad) pad_d = 1'b1;
              if (dec_defer) begin
                bump_df = 1'b1;
                if (df_last) begin
                  done_d = 1'b1;
                  res_d  = RES_DEADLINE;
                  rlen_d = '0;
                end
              end else begin
                done_d = 1'b1;
                res_d  = dec_code;
                rlen_d = (dec_code == RES_OK) ? rsp_count : '0;
              end
            end
            default: begin
              done_d = 1'b1;
              res_d  = RES_FAIL;
              rlen_d = '0;
            end
          endcase
          state_d = done_d ? S_IDLE : S_ISSUE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      rlen_q  <= '0;
      pad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      pad_q   <= pad_d;
      if (done_d) begin
        res_q  <= res_d;
        rlen_q <= rlen_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      cmd_q  <= req_cmd;
      addr_q <= req_addr;
      len_q  <= req_len;
      data_q <= req_wdata;
    end
  end

  assign xcv_valid = (state_q == S_ISSUE);
  assign xcv_cmd   = cmd_q;
  assign xcv_addr  = addr_q;
  assign xcv_len   = len_q;
  assign xcv_wdata = data_q;
  assign done      = done_q;
  assign result    = res_q;
  assign reply_len = rlen_q;
  assign pad_warn  = pad_q;

endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              xcv_valid,
  input logic              xcv_ready,
  input logic [3:0]        xcv_cmd,
  input logic [ADDR_W-1:0] xcv_addr,
  input logic [LEN_W-1:0]  xcv_len,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic [7:0]        rsp_header,
  input logic [LEN_W-1:0]  rsp_count,
  input logic              in_wait,
  input logic              done,
  input logic [2:0]        result,
  input logic [LEN_W-1:0]  reply_len,
  input logic              pad_warn
);

  logic reply_beat;
  assign reply_beat = in_wait && rsp_valid && (rsp_kind == 2'd0);

  assert_busy_holdoff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_valid |-> !req_ready);

  assert_issue_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xcv_valid && !xcv_ready) |=> (xcv_valid && $stable(xcv_cmd) &&
                                   $stable(xcv_addr) && $stable(xcv_len)));

  assert_ack_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_beat && rsp_header[7:4] == 4'd0) |=>
      (done && result == 3'd0 && reply_len == $past(rsp_count)));

  assert_nack_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_beat && (rsp_header[7:4] == 4'd1 || rsp_header[7:4] == 4'd4)) |=>
      (done && result == 3'd1));

  assert_i2c_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_beat && rsp_header[7:4] == 4'd8) |=> (done && result == 3'd4));

  assert_hard_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && rsp_valid && rsp_kind == 2'd2) |=> (done && result == 3'd6));

  assert_pad_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pad_warn |=> pad_warn);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_len_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 3'd0) |-> (reply_len == '0));

endmodule

bind aux_retry_ctrl aux_retry_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .xcv_valid  (xcv_valid),
  .xcv_ready  (xcv_ready),
  .xcv_cmd    (xcv_cmd),
  .xcv_addr   (xcv_addr),
  .xcv_len    (xcv_len),
  .rsp_valid  (rsp_valid),
  .rsp_kind   (rsp_kind),
  .rsp_header (rsp_header),
  .rsp_count  (rsp_count),
  .in_wait    (in_wait),
  .done       (done),
  .result     (result),
  .reply_len  (reply_len),
  .pad_warn   (pad_warn)
);

// File: tb/sim_aux_retry_ctrl.sv
module sim_aux_retry_ctrl;

  localparam int ADDR_W = 20;
  localparam int LEN_W  = 5;
  localparam int DATA_W = 128;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [3:0]        req_cmd;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [DATA_W-1:0] req_wdata;
  logic              xcv_valid;
  logic              xcv_ready;
  logic [3:0]        xcv_cmd;
  logic [ADDR_W-1:0] xcv_addr;
  logic [LEN_W-1:0]  xcv_len;
  logic [DATA_W-1:0] xcv_wdata;
  logic              rsp_valid;
  logic [1:0]        rsp_kind;
  logic [7:0]        rsp_header;
  logic [LEN_W-1:0]  rsp_count;
  logic              done;
  logic [2:0]        result;
  logic [LEN_W-1:0]  reply_len;
  logic              pad_warn;

  always #4 clk = ~clk;

  aux_retry_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .xcv_valid(xcv_valid), .xcv_ready(xcv_ready), .xcv_cmd(xcv_cmd),
    .xcv_addr(xcv_addr), .xcv_len(xcv_len), .xcv_wdata(xcv_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_header(rsp_header),
    .rsp_count(rsp_count), .done(done), .result(result),
    .reply_len(reply_len), .pad_warn(pad_warn)
  );

  typedef struct { int res; int len; int iss; string tag; } exp_t;
  typedef struct { int kind; int hdr; int cnt; } rsp_t;

  exp_t exp_q[$];
  rsp_t rsp_q[$];
  int total = 0;
  int bad   = 0;
  int issues = 0;
  logic [3:0]        cur_cmd;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic [DATA_W-1:0] cur_data;

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_rsp(int kind, int hdr, int cnt, int n);
    for (int i = 0; i < n; i++) begin
      rsp_t r;
      r.kind = kind; r.hdr = hdr; r.cnt = cnt;
      rsp_q.push_back(r);
    end
  endtask

  task automatic run_txn(int cmd, int addr, int len, int eres, int elen,
                         int eiss, string tag, bit poke);
    exp_t e;
    while (!req_ready) @(negedge clk);
    cur_cmd  = 4'(cmd);
    cur_addr = ADDR_W'(addr);
    cur_len  = LEN_W'(len);
    cur_data = {4{32'(addr * 7 + cmd)}};
    issues   = 0;
    e.res = eres; e.len = elen; e.iss = eiss; e.tag = tag;
    exp_q.push_back(e);
    req_cmd = cur_cmd; req_addr = cur_addr; req_len = cur_len;
    req_wdata = cur_data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_cmd = 4'hF; req_addr = '1; req_len = 5'd1; req_valid = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b0, "R1", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // Transceiver model
  initial begin
    xcv_ready = 1'b0; rsp_valid = 1'b0; rsp_kind = 2'd0;
    rsp_header = 8'h00; rsp_count = '0;
    forever begin
      @(negedge clk);
      if (rst_n && xcv_valid) begin
        rsp_t r;
        issues++;
        check(xcv_cmd == cur_cmd && xcv_addr == cur_addr && xcv_len == cur_len
              && xcv_wdata == cur_data, "R2", "issued request", int'(xcv_addr),
              int'(cur_addr));
        xcv_ready = 1'b1;
        @(negedge clk);
        xcv_ready = 1'b0;
        @(negedge clk);
        if (rsp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected extra issue", issues, 0);
          r.kind = 2; r.hdr = 0; r.cnt = 0;
        end else r = rsp_q.pop_front();
        rsp_kind = 2'(r.kind); rsp_header = 8'(r.hdr); rsp_count = LEN_W'(r.cnt);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) check(1'b0, "R11", "done without request", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(result) == e.res, e.tag, "result", int'(result), e.res);
          check(int'(reply_len) == e.len, e.tag, "reply_len", int'(reply_len), e.len);
          check(issues == e.iss, e.tag, "issue count", issues, e.iss);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0;
    req_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
    check(done == 1'b0, "R11", "reset done", int'(done), 0);
    check(xcv_valid == 1'b0, "R2", "reset xcv_valid", int'(xcv_valid), 0);
    check(pad_warn == 1'b0, "R9", "reset pad_warn", int'(pad_warn), 0);

    push_rsp(0, 8'h00, 4, 1);
    run_txn(9, 'h00100, 4, 0, 4, 1, "R3", 0);
    push_rsp(0, 8'h00, 16, 1);
    run_txn(1, 'h00050, 16, 0, 16, 1, "R3", 0);
    push_rsp(0, 8'h10, 3, 1);
    run_txn(8, 'h00200, 1, 1, 0, 1, "R4", 0);
    push_rsp(0, 8'h40, 0, 1);
    run_txn(0, 'h00030, 1, 1, 0, 1, "R4", 0);
    push_rsp(0, 8'h20, 0, 3); push_rsp(0, 8'h00, 2, 1);
    run_txn(9, 'h00300, 2, 0, 2, 4, "R5", 1);
    repeat (4) @(negedge clk);
    check(xcv_valid == 1'b0, "R1", "busy request ignored", int'(xcv_valid), 0);
    push_rsp(0, 8'h20, 0, 16);
    run_txn(9, 'h00400, 8, 2, 0, 16, "R5", 0);
    push_rsp(0, 8'h20, 0, 15); push_rsp(0, 8'h00, 8, 1);
    run_txn(9, 'h00410, 8, 0, 8, 16, "R5", 0);
    push_rsp(1, 0, 0, 4); push_rsp(0, 8'h00, 1, 1);
    run_txn(9, 'h00500, 1, 0, 1, 5, "R6", 0);
    push_rsp(1, 0, 0, 5);
    run_txn(9, 'h00510, 1, 3, 0, 5, "R6", 0);
    push_rsp(1, 0, 0, 4); push_rsp(0, 8'h00, 1, 1);
    run_txn(9, 'h00520, 1, 0, 1, 5, "R10", 0);
    push_rsp(0, 8'h20, 0, 15); push_rsp(1, 0, 0, 4); push_rsp(0, 8'h00, 6, 1);
    run_txn(9, 'h00530, 6, 0, 6, 20, "R10", 0);
    push_rsp(0, 8'h80, 5, 1);
    run_txn(1, 'h00050, 5, 4, 0, 1, "R7", 0);
    push_rsp(0, 8'h30, 5, 1);
    run_txn(9, 'h00600, 5, 5, 0, 1, "R8", 0);
    push_rsp(2, 0, 0, 1);
    run_txn(9, 'h00610, 5, 6, 0, 1, "R8", 0);
    check(pad_warn == 1'b0, "R9", "pad_warn before padded reply", int'(pad_warn), 0);
    push_rsp(0, 8'h05, 3, 1);
    run_txn(9, 'h00700, 3, 0, 3, 1, "R9", 0);
    check(pad_warn == 1'b1, "R9", "pad_warn after padded reply", int'(pad_warn), 1);
    push_rsp(0, 8'h00, 2, 1);
    run_txn(9, 'h00710, 2, 0, 2, 1, "R9", 0);
    check(pad_warn == 1'b1, "R9", "pad_warn sticky", int'(pad_warn), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule